// File: doc/BRIEF.md
# Bus Watchpoint Comparator Bank

This block holds a small bank of watchpoint comparators that observe a processor bus. Each comparator has a mode byte, an 18-bit address value and, for the first comparator only, a 16-bit data value. When a bus cycle meets the condition programmed into a comparator, the block raises that comparator's bit of a match vector for exactly one clock, one cycle after the bus cycle. In tag mode a comparator takes no notice of the bus. It fires instead when an execute-stage event input for a tagged opcode is raised for it.

Software reaches every comparator through one 8-byte register window. A select field in the window chooses which comparator's mode, address and data bytes the other offsets show. Writes are one byte wide: a strobe, a 3-bit offset and a data byte. Reads return the selected comparator's fields combinationally on the same offset port. After reset every register is zero, so every comparator is off.

Window layout, by offset: 0 mode byte; 1 address bits 17:16 in bits 1:0; 2 address bits 15:8; 3 address bits 7:0; 4 data bits 15:8; 5 data bits 7:0; 6 comparator select in bits 1:0; 7 unused. Mode byte bits: 0 enable, 1 invert-data, 2 direction-check, 3 direction (1 = read, 0 = write), 4 tag.

Top module: `wp_watch`

## Requirements
- R1: After reset all window offsets read 0 for every selection, and the match vector is 0.
- R2: A comparator whose mode bit 0 (enable) is 0 never raises its match bit, whatever the bus or tag inputs do.
- R3: With mode bit 2 (direction-check) at 0, a matching cycle fires on both reads (busRead=1) and writes (busRead=0).
- R4: With mode bit 2 at 1, mode bit 3 = 0 fires only on write cycles and mode bit 3 = 1 fires only on read cycles.
- R5: A bus match requires busValid and all 18 address bits equal to the stored address; a difference in any bit gives no match.
- R6: On comparator 0, mode bit 1 (invert-data) = 0 requires bus data equal to the stored data, and = 1 requires it to differ.
- R7: Comparators 1 to 3 ignore bus data. Their mode bit 1 is not stored and reads 0, and offsets 4 and 5 read 0 while they are selected.
- R8: With mode bit 4 (tag) set, a comparator ignores bus cycles, direction and invert-data, and fires when its own tagExec bit is 1.
- R9: The match bit is registered. It is high in the cycle after the qualifying cycle and low again one cycle later unless a new event qualifies.
- R10: Offset 6 bits 1:0 select the comparator shown at offsets 0 to 5 and read back as written. Offset 1 bits 7:2, mode byte bits 7:5 and offset 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Window byte write strobe |
| regOff | input | 3 | Window offset for writes and reads |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte at regOff |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | 18 | Bus address |
| busData | input | 16 | Bus data |
| busRead | input | 1 | Bus direction, 1 = read, 0 = write |
| tagExec | input | 4 | Per-comparator tagged opcode reached execute |
| matchPulse | output | 4 | Per-comparator registered match |

## Verification
The match path is driven with bus cycles that differ from a programmed hit in one dimension at a time: address bit 17 or bit 0, read versus write, and equal versus unequal data. Each pattern is run under both settings of the mode bit that governs that dimension, so a qualifier that is wrongly applied or wrongly ignored gives a different match vector. Tag-mode comparators share an address with bus-mode ones, which separates a bus hit from a tag event. A probe of the cycle after each hit separates a one-cycle pulse from a held level.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ADDR_W = 18;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic tag;
    logic dir;
    logic dirEn;
    logic invData;
    logic enable;
  } wpMode_t;

  typedef struct packed {
    logic       mode;
    logic       addrHi;
    logic       addrMid;
    logic       addrLo;
    logic       dataHi;
    logic       dataLo;
    logic [7:0] wbyte;
  } wpStrobe_t;
endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           regOff,
  input  logic [7:0]           wrData,
  input  wpMode_t              selMode,
  input  logic [ADDR_W-1:0]    selAddr,
  input  logic [DATA_W-1:0]    selData,
  output wpStrobe_t            strb,
  output logic [SEL_W-1:0]     sel,
  output logic [7:0]           rdData
);
  logic [SEL_W-1:0] selQ;

  always_comb begin
    strb         = '0;
    strb.wbyte   = wrData;
    strb.mode    = wrEn && (regOff == 3'd0);
    strb.addrHi  = wrEn && (regOff == 3'd1);
    strb.addrMid = wrEn && (regOff == 3'd2);
    strb.addrLo  = wrEn && (regOff == 3'd3);
    strb.dataHi  = wrEn && (regOff == 3'd4);
    strb.dataLo  = wrEn && (regOff == 3'd5);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= '0;
    else if (wrEn && regOff == 3'd6) selQ <= wrData[SEL_W-1:0];
  end

  assign sel = selQ;

  always_comb begin
    unique case (regOff)
      3'd0:    rdData = {3'b000, selMode};
      3'd1:    rdData = {6'b0, selAddr[17:16]};
      3'd2:    rdData = selAddr[15:8];
      3'd3:    rdData = selAddr[7:0];
      3'd4:    rdData = selData[15:8];
      3'd5:    rdData = selData[7:0];
      3'd6:    rdData = 8'(selQ);
      default: rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int SEL_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wpStrobe_t            strb,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 busValid,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busData,
  input  logic                 busRead,
  input  logic [NUM_CMP-1:0]   tagExec,
  output logic [NUM_CMP-1:0]   matchPulse,
  output wpMode_t              selMode,
  output logic [ADDR_W-1:0]    selAddr,
  output logic [DATA_W-1:0]    selData
);
  wpMode_t             modeArr [NUM_CMP];
  logic [ADDR_W-1:0]   addrArr [NUM_CMP];
  logic [DATA_W-1:0]   dataArr [NUM_CMP];
  logic [NUM_CMP-1:0]  hitVec;
  logic [NUM_CMP-1:0]  matchQ;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    localparam logic [4:0] ModeKeep = (i == 0) ? 5'h1F : 5'h1D;
    wpMode_t           modeQ;
    logic [ADDR_W-1:0] addrQ;
    logic              picked;
    logic              dataOk;
    logic              dirOk;
    logic              busHit;

    assign picked = (sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= '0;
        addrQ <= '0;
      end else if (picked) begin
        if (strb.mode)    modeQ         <= wpMode_t'(strb.wbyte[4:0] & ModeKeep);
        if (strb.addrHi)  addrQ[17:16]  <= strb.wbyte[1:0];
        if (strb.addrMid) addrQ[15:8]   <= strb.wbyte;
        if (strb.addrLo)  addrQ[7:0]    <= strb.wbyte;
      end
    end

    if (i == 0) begin : g_data
      logic [DATA_W-1:0] dataQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataQ <= '0;
        else if (picked) begin
          if (strb.dataHi) dataQ[15:8] <= strb.wbyte;
          if (strb.dataLo) dataQ[7:0]  <= strb.wbyte;
        end
      end
      assign dataOk     = (busData == dataQ) ^ modeQ.invData;
      assign dataArr[i] = dataQ;
    end else begin : g_nodata
      assign dataOk     = 1'b1;
      assign dataArr[i] = '0;
    end

    assign dirOk  = !modeQ.dirEn || (modeQ.dir == busRead);
    assign busHit = busValid && (busAddr == addrQ) && dirOk && dataOk;
    assign hitVec[i]  = modeQ.enable && (modeQ.tag ? tagExec[i] : busHit);
    assign modeArr[i] = modeQ;
    assign addrArr[i] = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= '0;
    else       matchQ <= hitVec;
  end

  assign matchPulse = matchQ;

  always_comb begin
    selMode = '0;
    selAddr = '0;
    selData = '0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (sel == SEL_W'(k)) begin
        selMode = modeArr[k];
        selAddr = addrArr[k];
        selData = dataArr[k];
      end
    end
  end
endmodule

// File: rtl/wp_watch.sv
module wp_watch
  import wp_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int SEL_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           regOff,
  input  logic [7:0]           wrData,
  output logic [7:0]           rdData,
  input  logic                 busValid,
  input  logic [17:0]          busAddr,
  input  logic [15:0]          busData,
  input  logic                 busRead,
  input  logic [NUM_CMP-1:0]   tagExec,
  output logic [NUM_CMP-1:0]   matchPulse
);
  wpStrobe_t         strb;
  logic [SEL_W-1:0]  sel;
  wpMode_t           selMode;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;

  wp_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regOff(regOff), .wrData(wrData),
    .selMode(selMode), .selAddr(selAddr), .selData(selData),
    .strb(strb), .sel(sel), .rdData(rdData)
  );

  wp_datapath #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sel(sel),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busRead(busRead), .tagExec(tagExec), .matchPulse(matchPulse),
    .selMode(selMode), .selAddr(selAddr), .selData(selData)
  );
endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk #(
  parameter int NUM_CMP = 4,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [2:0]         regOff,
  input logic [7:0]         wrData,
  input logic [7:0]         rdData,
  input logic               busValid,
  input logic [NUM_CMP-1:0] tagExec,
  input logic [NUM_CMP-1:0] matchPulse
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid && tagExec == '0) |=> (matchPulse == '0));

  p_addr_hi_pad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regOff == 3'd1) |-> (rdData[7:2] == 6'b0));

  p_mode_pad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regOff == 3'd0) |-> (rdData[7:5] == 3'b0));

  p_gap_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regOff == 3'd7) |-> (rdData == 8'h00));

  p_sel_echo_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regOff == 3'd6) ##1 (regOff == 3'd6)
      |-> (rdData[SEL_W-1:0] == $past(wrData[SEL_W-1:0])));
endmodule

bind wp_watch wp_watch_chk #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regOff(regOff), .wrData(wrData),
  .rdData(rdData), .busValid(busValid), .tagExec(tagExec),
  .matchPulse(matchPulse)
);

// File: tb/sim_wp_watch.sv
`timescale 1ns/1ps
module sim_wp_watch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  regOff = 3'd0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        busValid = 1'b0;
  logic [17:0] busAddr = '0;
  logic [15:0] busData = '0;
  logic        busRead = 1'b0;
  logic [3:0]  tagExec = '0;
  logic [3:0]  matchPulse;

  int total = 0;
  int bad = 0;
  logic [3:0] got;
  logic [7:0] rd;

  always #10 clk = ~clk;

  wp_watch u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regOff(regOff), .wrData(wrData),
    .rdData(rdData), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .busRead(busRead), .tagExec(tagExec),
    .matchPulse(matchPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] off, input logic [7:0] d);
    wrEn = 1'b1; regOff = off; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] off, output logic [7:0] d);
    regOff = off;
    #1;
    d = rdData;
  endtask

  task automatic setCmp(input logic [1:0] s, input logic [7:0] mode,
                        input logic [17:0] a, input logic [15:0] d);
    wreg(3'd6, {6'b0, s});
    wreg(3'd0, mode);
    wreg(3'd1, {6'b0, a[17:16]});
    wreg(3'd2, a[15:8]);
    wreg(3'd3, a[7:0]);
    wreg(3'd4, d[15:8]);
    wreg(3'd5, d[7:0]);
  endtask

  // drive one cycle of stimulus at a falling edge, sample the pulse one edge later
  task automatic probe(input logic v, input logic [17:0] a, input logic [15:0] d,
                       input logic r, input logic [3:0] t, output logic [3:0] m);
    busValid = v; busAddr = a; busData = d; busRead = r; tagExec = t;
    @(negedge clk);
    m = matchPulse;
    busValid = 1'b0; tagExec = '0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) begin
      wrEn = 1'b0; regOff = 3'd6; wrData = 8'(s);
      wrEn = 1'b1; @(negedge clk); wrEn = 1'b0;
      for (int o = 0; o < 6; o++) begin
        rreg(3'(o), rd);
        check("R1 reset readback", 16'(rd), 16'h0);
      end
    end
    wreg(3'd6, 8'h00);
    check("R1 reset match", 16'(matchPulse), 16'h0);
  endtask

  task automatic t_enable;
    setCmp(2'd3, 8'h00, 18'h21234, 16'h0000);
    setCmp(2'd0, 8'h00, 18'h21234, 16'hBEEF);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R2 disabled quiet", 16'(got), 16'h0);
    wreg(3'd0, 8'h01);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R2 enabled fires", 16'(got), 16'h1);
  endtask

  task automatic t_addr;
    probe(1'b1, 18'h01234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R5 addr bit17 differs", 16'(got), 16'h0);
    probe(1'b1, 18'h21235, 16'hBEEF, 1'b0, 4'h0, got);
    check("R5 addr bit0 differs", 16'(got), 16'h0);
    probe(1'b0, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R5 no busValid", 16'(got), 16'h0);
  endtask

  task automatic t_dir_off;
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b1, 4'h0, got);
    check("R3 read fires", 16'(got), 16'h1);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R3 write fires", 16'(got), 16'h1);
  endtask

  task automatic t_dir_on;
    wreg(3'd0, 8'h05);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R4 write-only write", 16'(got), 16'h1);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b1, 4'h0, got);
    check("R4 write-only read", 16'(got), 16'h0);
    wreg(3'd0, 8'h0D);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b1, 4'h0, got);
    check("R4 read-only read", 16'(got), 16'h1);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R4 read-only write", 16'(got), 16'h0);
    wreg(3'd0, 8'h01);
  endtask

  task automatic t_data;
    probe(1'b1, 18'h21234, 16'hBEEE, 1'b0, 4'h0, got);
    check("R6 equal mode mismatch", 16'(got), 16'h0);
    wreg(3'd0, 8'h03);
    probe(1'b1, 18'h21234, 16'hBEEE, 1'b0, 4'h0, got);
    check("R6 invert mismatch fires", 16'(got), 16'h1);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R6 invert equal quiet", 16'(got), 16'h0);
    wreg(3'd0, 8'h01);
  endtask

  task automatic t_other;
    setCmp(2'd1, 8'h03, 18'h00100, 16'h1234);
    rreg(3'd0, rd);
    check("R7 invert bit not kept", 16'(rd), 16'h01);
    rreg(3'd4, rd);
    check("R7 data hi zero", 16'(rd), 16'h0);
    rreg(3'd5, rd);
    check("R7 data lo zero", 16'(rd), 16'h0);
    probe(1'b1, 18'h00100, 16'h5555, 1'b1, 4'h0, got);
    check("R7 data ignored", 16'(got), 16'h2);
  endtask

  task automatic t_tag;
    setCmp(2'd2, 8'h1F, 18'h21234, 16'h0000);
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h0, got);
    check("R8 tag ignores bus", 16'(got), 16'h1);
    probe(1'b0, 18'h0, 16'h0, 1'b0, 4'h4, got);
    check("R8 tag event fires", 16'(got), 16'h4);
    probe(1'b0, 18'h0, 16'h0, 1'b0, 4'h8, got);
    check("R2 disabled tag quiet", 16'(got), 16'h0);
  endtask

  task automatic t_pulse;
    probe(1'b1, 18'h21234, 16'hBEEF, 1'b0, 4'h4, got);
    check("R9 pulse high", 16'(got), 16'h5);
    @(negedge clk);
    check("R9 pulse drops", 16'(matchPulse), 16'h0);
  endtask

  task automatic t_window;
    wreg(3'd6, 8'h00);
    wreg(3'd1, 8'hFF);
    rreg(3'd1, rd);
    check("R10 addr hi pad", 16'(rd), 16'h03);
    rreg(3'd7, rd);
    check("R10 offset 7 zero", 16'(rd), 16'h0);
    rreg(3'd6, rd);
    check("R10 select readback", 16'(rd), 16'h0);
    rreg(3'd4, rd);
    check("R10 cmp0 data hi", 16'(rd), 16'hBE);
    wreg(3'd6, 8'h01);
    rreg(3'd3, rd);
    check("R10 cmp1 addr lo", 16'(rd), 16'h00);
    rreg(3'd2, rd);
    check("R10 cmp1 addr mid", 16'(rd), 16'h01);
    wreg(3'd6, 8'h02);
    rreg(3'd0, rd);
    check("R10 cmp2 mode", 16'(rd), 16'h1D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_addr;
    t_dir_off;
    t_dir_on;
    t_data;
    t_other;
    t_tag;
    t_pulse;
    t_window;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule